// File: doc/BRIEF.md
# Disk Pack Controller Command and Status Register File

This block is the programmed-I/O front end of a disk pack controller with an 18-bit data path and up to eight drives. The processor talks to it with short pulse codes in two groups. A pulse can test a condition and answer with a skip. It can read back a status word or a register. It can load the disk address, the memory address or the word count. It can also rewrite the upper, software-owned field of the first status word in one of four ways.

Two status words are presented. Each mixes flags that stay set until cleared with bits that follow the drive chosen by the unit field at every moment. An error summary bit and a single interrupt request are derived from these two words. Whenever a rewrite of the command field leaves the go bit set, the block checks the selected drive. If that drive is not already working, the block sets busy and sends a one-cycle go strobe, with the unit and function, to a drive sequencer. That sequencer later releases busy, signals completion, sets attention bits and reports the errors it finds. While busy, every load-type pulse is refused and flagged as a programming error.

Top module: `dpk_regfile`

## Requirements
- R1: After synchronous reset both status words read zero (with all drives attached, idle, writable and on cylinder 0), the disk address, memory address and word count read zero, and the block is not busy.
- R2: In group 0, pulse 02 returns status A and 22 returns status B. In group 1, pulse 02 returns the selected drive's cylinder, 22 the disk address, 42 the memory address and 62 the word count (all codes octal). Every other pulse returns the accumulator unchanged.
- R3: Skip tests: group 0 pulse 01 skips on done, error or any attention; 21 on any attention; 41 on done; 61 on error. Group 1 pulse 21 always skips.
- R4: Group 0 pulse 04 loads the disk address, whose sector is bits 3:0, surface bits 9:5 and cylinder bits 17:10. A sector of 10 or more sets status A bit 5, a surface of 20 or more sets bit 6, and a cylinder of 203 or more sets bit 7. These flags stay set until reset.
- R5: Group 1 pulses 04, 24, 44 and 64 rewrite status A bits 17:9 (unit 17:15, function 14:12, done-interrupt enable 11, attention-interrupt enable 10, go 9). Pulse 04 clears the field, 24 ANDs the accumulator into it, 44 ORs the accumulator into it, and 64 replaces it. Bits 8:0 are not changed.
- R6: When a field rewrite leaves go set and the selected drive is not active, go_strobe pulses for one cycle with that unit and function, and busy is set. Status A bits 4 (header not found) and 1 (done) are cleared, as are status B bits 8:2 and the attention bit of that unit.
- R7: When a field rewrite leaves go set and the selected drive is active, no strobe is issued and busy stays clear.
- R8: While busy, any pulse whose low three bits are 4 sets status B bit 8 (programming error) and has no other effect.
- R9: Group 0 pulse 24 clears status A bits 4 and 1 and status B bits 8:2. The nonexistent-address flags (A bits 7:5), the write-lock error (A bit 8) and the attention bits are kept.
- R10: Status A bit 0 is the OR of A bits 8:4 and 2 and of B bits 9:2.
- R11: Per selected drive: A bit 3 shows write lock. A detached drive shows B bits 9 (unsafe) and 0 (not ready). An attached, active, seeking drive shows B bits 1 and 0. An attached idle drive whose cylinder is 203 or more shows A bit 2 (seek incomplete).
- R12: irq is high when (A bit 1 or A bit 0) with A bit 11 set, or when any attention bit (B bits 17:10, drive n at bit 17-n) is set with A bit 10 set.
- R13: seq_release clears busy, seq_done sets A bit 1, seq_attn[n] sets B bit 17-n, and seq_set_a and seq_set_b set only the latched flag bits (A 8:4; B 8:2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pio_valid | input | 1 | A pulse is present this cycle |
| pio_group | input | 1 | Pulse group select (0 or 1) |
| pio_pulse | input | 6 | Pulse code, two octal digits |
| pio_acc_in | input | 18 | Accumulator value sent with the pulse |
| pio_acc_out | output | 18 | Value returned to the accumulator |
| pio_skip | output | 1 | Skip answer for the present pulse |
| drv_attached | input | NDRV | Drive has media mounted |
| drv_active | input | NDRV | Drive is carrying out an operation |
| drv_seeking | input | NDRV | Drive operation is a seek or recalibrate |
| drv_wlock | input | NDRV | Drive is write locked |
| drv_cyl | input | NDRV*CYLW | Current cylinder of each drive, drive n at slice n |
| seq_release | input | 1 | Sequencer frees the controller (clears busy) |
| seq_done | input | 1 | Sequencer signals completion (sets done) |
| seq_attn | input | NDRV | Sequencer raises attention per drive |
| seq_set_a | input | 18 | Error bits to set in status A (latched bits only) |
| seq_set_b | input | 18 | Error bits to set in status B (latched bits only) |
| go_strobe | output | 1 | One-cycle command start to the sequencer |
| go_unit | output | 3 | Unit for the started command |
| go_func | output | 3 | Function for the started command |
| xfer_da | output | 18 | Disk address register |
| xfer_ma | output | 18 | Memory address register |
| xfer_wc | output | 18 | Word count register |
| busy | output | 1 | Controller busy |
| irq | output | 1 | Interrupt request |

## Verification
The address check is swept over every sector value, every surface value and every cylinder value, each with the other two fields kept legal. This separates the three limits and shows any off-by-one at 10, 20 or 203. The selected-drive bits are swept over all eight units and all 32 combinations of attached, active, seeking, write lock and out-of-range cylinder. This tells the priority of detached over active over idle apart, and shows a wrong unit index. The four field rewrite modes are tried against several old-value and accumulator patterns, with junk in the low accumulator bits. The interrupt and skip logic is tried with every mix of enables and of done, error and attention.

// File: rtl/dpk_pkg.sv
package dpk_pkg;

  localparam int WORD = 18;

  // status A bit positions
  localparam int A_IE_DONE = 11;
  localparam int A_IE_ATTN = 10;
  localparam int A_GO      = 9;
  localparam int A_WLERR   = 8;
  localparam int A_NXCYL   = 7;
  localparam int A_NXSURF  = 6;
  localparam int A_NXSECT  = 5;
  localparam int A_NOHDR   = 4;
  localparam int A_SELWL   = 3;
  localparam int A_SEEKINC = 2;
  localparam int A_DONE    = 1;
  localparam int A_ERR     = 0;

  // status B bit positions
  localparam int B_UNSAFE  = 9;
  localparam int B_PROGERR = 8;
  localparam int B_SEEKING = 1;
  localparam int B_NOTRDY  = 0;

  localparam logic [WORD-1:0] A_FIELD    = 18'o777000;
  localparam logic [WORD-1:0] A_LATCHED  = 18'o000762;
  localparam logic [WORD-1:0] A_ERRMASK  = 18'o000764;
  localparam logic [WORD-1:0] A_CLRMASK  = 18'o000022;
  localparam logic [WORD-1:0] B_ERRFLAGS = 18'o000774;
  localparam logic [WORD-1:0] B_ERRMASK  = 18'o001774;
  localparam logic [WORD-1:0] B_ATTNS    = 18'o776000;

  typedef enum logic [4:0] {
    OP_NONE, OP_SKIP_ANY, OP_SKIP_ATTN, OP_SKIP_DONE, OP_SKIP_ERR, OP_SKIP_ONE,
    OP_RD_STA, OP_RD_STB, OP_RD_CYL, OP_RD_DA, OP_RD_MA, OP_RD_WC,
    OP_LD_DA, OP_CLR_STAT, OP_LD_MA, OP_LD_WC,
    OP_FLD_CLR, OP_FLD_AND, OP_FLD_OR, OP_FLD_SET
  } op_e;

  function automatic logic [3:0] da_sector(input logic [WORD-1:0] da);
    return da[3:0];
  endfunction

  function automatic logic [4:0] da_surface(input logic [WORD-1:0] da);
    return da[9:5];
  endfunction

  function automatic logic [7:0] da_cylinder(input logic [WORD-1:0] da);
    return da[17:10];
  endfunction

  // rewrite of the software field; low bits always kept from old
  function automatic logic [WORD-1:0] field_write(input op_e op,
                                                  input logic [WORD-1:0] old_w,
                                                  input logic [WORD-1:0] acc);
    logic [WORD-1:0] r;
    case (op)
      OP_FLD_CLR: r = old_w & ~A_FIELD;
      OP_FLD_AND: r = old_w & (acc | ~A_FIELD);
      OP_FLD_OR:  r = old_w | (acc & A_FIELD);
      OP_FLD_SET: r = (old_w & ~A_FIELD) | (acc & A_FIELD);
      default:    r = old_w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dpk_pulse_decode.sv
module dpk_pulse_decode
  import dpk_pkg::*;
(
  input  logic       valid,
  input  logic       group,
  input  logic [5:0] pulse,
  output op_e        op,
  output logic       load_kind
);

  assign load_kind = valid && (pulse[2:0] == 3'd4);

  always_comb begin
    op = OP_NONE;
    if (valid) begin
      if (!group) begin
        case (pulse)
          6'o01:   op = OP_SKIP_ANY;
          6'o21:   op = OP_SKIP_ATTN;
          6'o41:   op = OP_SKIP_DONE;
          6'o61:   op = OP_SKIP_ERR;
          6'o02:   op = OP_RD_STA;
          6'o22:   op = OP_RD_STB;
          6'o04:   op = OP_LD_DA;
          6'o24:   op = OP_CLR_STAT;
          6'o44:   op = OP_LD_MA;
          6'o64:   op = OP_LD_WC;
          default: op = OP_NONE;
        endcase
      end else begin
        case (pulse)
          6'o21:   op = OP_SKIP_ONE;
          6'o02:   op = OP_RD_CYL;
          6'o22:   op = OP_RD_DA;
          6'o42:   op = OP_RD_MA;
          6'o62:   op = OP_RD_WC;
          6'o04:   op = OP_FLD_CLR;
          6'o24:   op = OP_FLD_AND;
          6'o44:   op = OP_FLD_OR;
          6'o64:   op = OP_FLD_SET;
          default: op = OP_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/dpk_unit_view.sv
module dpk_unit_view #(
  parameter int NDRV    = 8,
  parameter int CYLW    = 8,
  parameter int NUM_CYL = 203
) (
  input  logic [2:0]         unit,
  input  logic [NDRV-1:0]    attached,
  input  logic [NDRV-1:0]    active,
  input  logic [NDRV-1:0]    seeking,
  input  logic [NDRV-1:0]    wlock,
  input  logic [NDRV*CYLW-1:0] cyl_flat,
  output logic               sel_wlock,
  output logic               sel_seekinc,
  output logic               sel_unsafe,
  output logic               sel_seeking,
  output logic               sel_notrdy,
  output logic               sel_active,
  output logic [CYLW-1:0]    sel_cyl
);

  localparam logic [CYLW:0] CYL_LIMIT = (CYLW+1)'(NUM_CYL);

  logic att, act, skg;

  always_comb begin
    att       = 1'b0;
    act       = 1'b0;
    skg       = 1'b0;
    sel_wlock = 1'b0;
    sel_cyl   = '0;
    for (int i = 0; i < NDRV; i++) begin
      if (unit == 3'(i)) begin
        att       = attached[i];
        act       = active[i];
        skg       = seeking[i];
        sel_wlock = wlock[i];
        sel_cyl   = cyl_flat[i*CYLW +: CYLW];
      end
    end
    sel_active  = att && act;
    sel_unsafe  = !att;
    sel_seeking = att && act && skg;
    sel_notrdy  = !att || (act && skg);
    sel_seekinc = att && !act && ({1'b0, sel_cyl} >= CYL_LIMIT);
  end

endmodule

// File: rtl/dpk_status_merge.sv
module dpk_status_merge
  import dpk_pkg::*;
(
  input  logic [WORD-1:0] sta_lat,
  input  logic [WORD-1:0] stb_lat,
  input  logic            sel_wlock,
  input  logic            sel_seekinc,
  input  logic            sel_unsafe,
  input  logic            sel_seeking,
  input  logic            sel_notrdy,
  output logic [WORD-1:0] sta_word,
  output logic [WORD-1:0] stb_word,
  output logic            any_attn,
  output logic            irq
);

  logic [WORD-1:0] sta_pre;
  logic            err_sum;

  always_comb begin
    sta_pre = sta_lat;
    sta_pre[A_SELWL]   = sel_wlock;
    sta_pre[A_SEEKINC] = sel_seekinc;
    sta_pre[A_ERR]     = 1'b0;
    stb_word = stb_lat;
    stb_word[B_UNSAFE]  = sel_unsafe;
    stb_word[B_SEEKING] = sel_seeking;
    stb_word[B_NOTRDY]  = sel_notrdy;
    err_sum  = (|(sta_pre & A_ERRMASK)) || (|(stb_word & B_ERRMASK));
    sta_word = sta_pre;
    sta_word[A_ERR] = err_sum;
    any_attn = |(stb_word & B_ATTNS);
    irq = ((sta_word[A_DONE] || err_sum) && sta_word[A_IE_DONE]) ||
          (any_attn && sta_word[A_IE_ATTN]);
  end

endmodule

// File: rtl/dpk_regfile.sv
module dpk_regfile
  import dpk_pkg::*;
#(
  parameter int NDRV     = 8,
  parameter int CYLW     = 8,
  parameter int NUM_SECT = 10,
  parameter int NUM_SURF = 20,
  parameter int NUM_CYL  = 203
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pio_valid,
  input  logic                 pio_group,
  input  logic [5:0]           pio_pulse,
  input  logic [17:0]          pio_acc_in,
  output logic [17:0]          pio_acc_out,
  output logic                 pio_skip,
  input  logic [NDRV-1:0]      drv_attached,
  input  logic [NDRV-1:0]      drv_active,
  input  logic [NDRV-1:0]      drv_seeking,
  input  logic [NDRV-1:0]      drv_wlock,
  input  logic [NDRV*CYLW-1:0] drv_cyl,
  input  logic                 seq_release,
  input  logic                 seq_done,
  input  logic [NDRV-1:0]      seq_attn,
  input  logic [17:0]          seq_set_a,
  input  logic [17:0]          seq_set_b,
  output logic                 go_strobe,
  output logic [2:0]           go_unit,
  output logic [2:0]           go_func,
  output logic [17:0]          xfer_da,
  output logic [17:0]          xfer_ma,
  output logic [17:0]          xfer_wc,
  output logic                 busy,
  output logic                 irq
);

  localparam logic [4:0] SECT_LIM = 5'(NUM_SECT);
  localparam logic [5:0] SURF_LIM = 6'(NUM_SURF);
  localparam logic [8:0] CYL_LIM  = 9'(NUM_CYL);

  // registered state
  logic [WORD-1:0] sta_q, stb_q, da_q, ma_q, wc_q;
  logic            busy_q, go_q;
  logic [2:0]      go_unit_q, go_func_q;

  // next state and named events
  logic [WORD-1:0] sta_n, stb_n, da_n, ma_n, wc_n;
  logic            busy_n, go_now, blocked_load;
  logic [2:0]      cmd_unit;
  logic [WORD-1:0] sta_after_fld;

  op_e  op;
  logic load_kind;

  logic sel_wlock, sel_seekinc, sel_unsafe, sel_seeking, sel_notrdy, sel_active;
  logic [CYLW-1:0] sel_cyl;
  logic [WORD-1:0] sta_word, stb_word;
  logic any_attn;

  // unit lookup for the go check, taken from the field after the rewrite
  logic [7:0] act_pad, att_pad;
  genvar g;
  generate
    for (g = 0; g < 8; g++) begin : g_pad
      if (g < NDRV) begin : g_real
        assign act_pad[g] = drv_active[g];
        assign att_pad[g] = drv_attached[g];
      end else begin : g_none
        assign act_pad[g] = 1'b0;
        assign att_pad[g] = 1'b0;
      end
    end
  endgenerate

  dpk_pulse_decode u_decode (
    .valid     (pio_valid),
    .group     (pio_group),
    .pulse     (pio_pulse),
    .op        (op),
    .load_kind (load_kind)
  );

  dpk_unit_view #(.NDRV(NDRV), .CYLW(CYLW), .NUM_CYL(NUM_CYL)) u_view (
    .unit        (sta_q[17:15]),
    .attached    (drv_attached),
    .active      (drv_active),
    .seeking     (drv_seeking),
    .wlock       (drv_wlock),
    .cyl_flat    (drv_cyl),
    .sel_wlock   (sel_wlock),
    .sel_seekinc (sel_seekinc),
    .sel_unsafe  (sel_unsafe),
    .sel_seeking (sel_seeking),
    .sel_notrdy  (sel_notrdy),
    .sel_active  (sel_active),
    .sel_cyl     (sel_cyl)
  );

  dpk_status_merge u_merge (
    .sta_lat     (sta_q),
    .stb_lat     (stb_q),
    .sel_wlock   (sel_wlock),
    .sel_seekinc (sel_seekinc),
    .sel_unsafe  (sel_unsafe),
    .sel_seeking (sel_seeking),
    .sel_notrdy  (sel_notrdy),
    .sta_word    (sta_word),
    .stb_word    (stb_word),
    .any_attn    (any_attn),
    .irq         (irq)
  );

  assign blocked_load  = load_kind && busy_q;
  assign sta_after_fld = field_write(op, sta_q, pio_acc_in);
  assign cmd_unit      = sta_after_fld[17:15];

  always_comb begin
    sta_n  = sta_q;
    stb_n  = stb_q;
    da_n   = da_q;
    ma_n   = ma_q;
    wc_n   = wc_q;
    busy_n = busy_q;
    go_now = 1'b0;

    if (blocked_load) begin
      stb_n[B_PROGERR] = 1'b1;
    end else begin
      case (op)
        OP_LD_DA: begin
          da_n = pio_acc_in;
          if ({1'b0, da_sector(pio_acc_in)} >= SECT_LIM)   sta_n[A_NXSECT] = 1'b1;
          if ({1'b0, da_surface(pio_acc_in)} >= SURF_LIM)  sta_n[A_NXSURF] = 1'b1;
          if ({1'b0, da_cylinder(pio_acc_in)} >= CYL_LIM)  sta_n[A_NXCYL]  = 1'b1;
        end
        OP_CLR_STAT: begin
          sta_n = sta_q & ~A_CLRMASK;
          stb_n = stb_q & ~B_ERRFLAGS;
        end
        OP_LD_MA: ma_n = pio_acc_in;
        OP_LD_WC: wc_n = pio_acc_in;
        OP_FLD_CLR, OP_FLD_AND, OP_FLD_OR, OP_FLD_SET: begin
          sta_n = sta_after_fld;
          if (sta_after_fld[A_GO] && !(att_pad[cmd_unit] && act_pad[cmd_unit])) begin
            go_now = 1'b1;
            busy_n = 1'b1;
            sta_n  = sta_after_fld & ~A_CLRMASK;
            stb_n  = stb_q & ~B_ERRFLAGS;
            stb_n[17 - int'(cmd_unit)] = 1'b0;
          end
        end
        default: ;
      endcase
    end

    // sequencer events are applied after the pulse effects
    if (seq_release && !go_now) busy_n = 1'b0;
    if (seq_done) sta_n[A_DONE] = 1'b1;
    sta_n = sta_n | (seq_set_a & A_LATCHED & ~(18'(1) << A_DONE));
    stb_n = stb_n | (seq_set_b & B_ERRFLAGS);
    for (int i = 0; i < NDRV; i++) begin
      if (seq_attn[i]) stb_n[17 - i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sta_q     <= '0;
      stb_q     <= '0;
      da_q      <= '0;
      ma_q      <= '0;
      wc_q      <= '0;
      busy_q    <= 1'b0;
      go_q      <= 1'b0;
      go_unit_q <= '0;
      go_func_q <= '0;
    end else begin
      sta_q     <= sta_n;
      stb_q     <= stb_n;
      da_q      <= da_n;
      ma_q      <= ma_n;
      wc_q      <= wc_n;
      busy_q    <= busy_n;
      go_q      <= go_now;
      if (go_now) begin
        go_unit_q <= sta_after_fld[17:15];
        go_func_q <= sta_after_fld[14:12];
      end
    end
  end

  always_comb begin
    pio_acc_out = pio_acc_in;
    case (op)
      OP_RD_STA: pio_acc_out = sta_word;
      OP_RD_STB: pio_acc_out = stb_word;
      OP_RD_CYL: pio_acc_out = 18'(sel_cyl);
      OP_RD_DA:  pio_acc_out = da_q;
      OP_RD_MA:  pio_acc_out = ma_q;
      OP_RD_WC:  pio_acc_out = wc_q;
      default: ;
    endcase
  end

  always_comb begin
    case (op)
      OP_SKIP_ANY:  pio_skip = sta_word[A_DONE] || sta_word[A_ERR] || any_attn;
      OP_SKIP_ATTN: pio_skip = any_attn;
      OP_SKIP_DONE: pio_skip = sta_word[A_DONE];
      OP_SKIP_ERR:  pio_skip = sta_word[A_ERR];
      OP_SKIP_ONE:  pio_skip = 1'b1;
      default:      pio_skip = 1'b0;
    endcase
  end

  assign go_strobe = go_q;
  assign go_unit   = go_unit_q;
  assign go_func   = go_func_q;
  assign xfer_da   = da_q;
  assign xfer_ma   = ma_q;
  assign xfer_wc   = wc_q;
  assign busy      = busy_q;

endmodule

// File: rtl/dpk_regfile_chk.sv
module dpk_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        blocked_load,
  input logic        go_now,
  input logic        go_strobe,
  input logic        seq_release,
  input logic        prog_err,
  input logic [17:0] da_q,
  input logic [17:0] ma_q
);

  // R8: refused load raises the programming error flag
  a_r8_refused_load_flags: assert property (@(posedge clk) disable iff (rst)
    blocked_load |=> prog_err);

  // R8: refused load leaves the address registers untouched
  a_r8_refused_load_holds: assert property (@(posedge clk) disable iff (rst)
    blocked_load |=> ($stable(da_q) && $stable(ma_q)));

  // R6: strobe seen only while busy
  a_r6_strobe_with_busy: assert property (@(posedge clk) disable iff (rst)
    go_strobe |-> busy);

  // R6: strobe lasts a single cycle
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
    go_strobe |=> !go_strobe);

  // R13: release frees the controller unless a start happens in that cycle
  a_r13_release_frees: assert property (@(posedge clk) disable iff (rst)
    (seq_release && !go_now) |=> !busy);

endmodule

bind dpk_regfile dpk_regfile_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy_q),
  .blocked_load (blocked_load),
  .go_now       (go_now),
  .go_strobe    (go_strobe),
  .seq_release  (seq_release),
  .prog_err     (stb_word[8]),
  .da_q         (da_q),
  .ma_q         (ma_q)
);

// File: tb/dpk_regfile_bench.sv
`timescale 1ns/1ps
module dpk_regfile_bench;

  localparam int NDRV = 8;
  localparam int CYLW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pio_valid = 1'b0, pio_group = 1'b0;
  logic [5:0]  pio_pulse = '0;
  logic [17:0] pio_acc_in = '0;
  logic [17:0] pio_acc_out;
  logic        pio_skip;
  logic [NDRV-1:0] drv_attached = '1, drv_active = '0, drv_seeking = '0, drv_wlock = '0;
  logic [NDRV*CYLW-1:0] drv_cyl = '0;
  logic seq_release = 1'b0, seq_done = 1'b0;
  logic [NDRV-1:0] seq_attn = '0;
  logic [17:0] seq_set_a = '0, seq_set_b = '0;
  logic go_strobe, busy, irq;
  logic [2:0] go_unit, go_func;
  logic [17:0] xfer_da, xfer_ma, xfer_wc;

  int checks = 0;
  int errors = 0;
  logic [17:0] rd;
  logic sk, gs;
  logic [2:0] gu, gf;

  always #2 clk = ~clk;

  dpk_regfile #(.NDRV(NDRV), .CYLW(CYLW)) u_dpk_regfile (
    .clk(clk), .rst(rst),
    .pio_valid(pio_valid), .pio_group(pio_group), .pio_pulse(pio_pulse),
    .pio_acc_in(pio_acc_in), .pio_acc_out(pio_acc_out), .pio_skip(pio_skip),
    .drv_attached(drv_attached), .drv_active(drv_active), .drv_seeking(drv_seeking),
    .drv_wlock(drv_wlock), .drv_cyl(drv_cyl),
    .seq_release(seq_release), .seq_done(seq_done), .seq_attn(seq_attn),
    .seq_set_a(seq_set_a), .seq_set_b(seq_set_b),
    .go_strobe(go_strobe), .go_unit(go_unit), .go_func(go_func),
    .xfer_da(xfer_da), .xfer_ma(xfer_ma), .xfer_wc(xfer_wc),
    .busy(busy), .irq(irq)
  );

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %06o expected %06o", tag, act, exp);
    end
  endtask

  // one pulse per cycle; called at a falling edge
  task automatic pio(input logic grp, input logic [5:0] code, input logic [17:0] acc);
    pio_group = grp; pio_pulse = code; pio_acc_in = acc; pio_valid = 1'b1;
    #1;
    rd = pio_acc_out; sk = pio_skip;
    @(negedge clk);
    pio_valid = 1'b0;
    gs = go_strobe; gu = go_unit; gf = go_func;
  endtask

  task automatic seq(input logic rel, input logic dn, input logic [NDRV-1:0] at,
                     input logic [17:0] sa, input logic [17:0] sb);
    seq_release = rel; seq_done = dn; seq_attn = at; seq_set_a = sa; seq_set_b = sb;
    @(negedge clk);
    seq_release = 1'b0; seq_done = 1'b0; seq_attn = '0; seq_set_a = '0; seq_set_b = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [17:0] exp_field(input int mode, input logic [17:0] old_f,
                                            input logic [17:0] acc);
    logic [8:0] o, a, r;
    o = old_f[17:9]; a = acc[17:9];
    case (mode)
      0: r = 9'd0;
      1: r = o & a;
      2: r = o | a;
      default: r = a;
    endcase
    return {r, 9'd0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    pio(0, 6'o02, 0); chk("R1 status A", rd, 0);
    pio(0, 6'o22, 0); chk("R1 status B", rd, 0);
    pio(1, 6'o22, 0); chk("R1 disk addr", rd, 0);
    pio(1, 6'o42, 0); chk("R1 mem addr", rd, 0);
    pio(1, 6'o62, 0); chk("R1 word count", rd, 0);
    chk("R1 busy", 18'(busy), 0);

    // R2 loads and readbacks
    pio(0, 6'o04, 18'o012347); pio(1, 6'o22, 0); chk("R2 disk addr", rd, 18'o012347);
    pio(0, 6'o44, 18'o123456); pio(1, 6'o42, 0); chk("R2 mem addr", rd, 18'o123456);
    pio(0, 6'o64, 18'o765432); pio(1, 6'o62, 0); chk("R2 word count", rd, 18'o765432);
    pio(0, 6'o03, 18'o000135); chk("R2 passthrough", rd, 18'o000135);
    pio(0, 6'o02, 0); chk("R2 legal address no flags", rd, 0);

    // R4 sweeps of each address field
    for (int s = 0; s < 16; s++) begin
      do_reset();
      pio(0, 6'o04, 18'(s));
      pio(0, 6'o02, 0);
      chk("R4 sector", rd, (s >= 10) ? 18'o000041 : 18'o0);
    end
    for (int s = 0; s < 32; s++) begin
      do_reset();
      pio(0, 6'o04, 18'(s * 32));
      pio(0, 6'o02, 0);
      chk("R4 surface", rd, (s >= 20) ? 18'o000101 : 18'o0);
    end
    for (int c = 0; c < 256; c++) begin
      do_reset();
      pio(0, 6'o04, 18'(c * 1024));
      pio(0, 6'o02, 0);
      chk("R4 cylinder", rd, (c >= 203) ? 18'o000201 : 18'o0);
    end
    // R4 flags persist across a legal reload and a clear-status pulse
    pio(0, 6'o04, 0); pio(0, 6'o24, 0); pio(0, 6'o02, 0);
    chk("R4 sticky", rd, 18'o000201);

    // R5 field rewrite modes
    begin
      logic [17:0] olds [4] = '{18'o000000, 18'o774000, 18'o524000, 18'o252000};
      logic [17:0] accs [4] = '{18'o776777, 18'o000000, 18'o122456, 18'o654321};
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          for (int m = 0; m < 4; m++) begin
            do_reset();
            seq(0, 1, '0, 0, 0);
            pio(1, 6'o64, olds[i]);
            pio(1, 6'(8 * (2 * m) + 4), accs[j]);
            pio(0, 6'o02, 0);
            chk("R5 field mode", rd, exp_field(m, olds[i], accs[j]) | 18'o2);
          end
        end
      end
    end

    // R6 start, R8 interlock, R13 release
    do_reset();
    pio(0, 6'o44, 18'o000055);
    seq(0, 1, 8'b0010_1000, 18'o000020, 18'o000100);
    pio(1, 6'o64, 18'o321000);
    chk("R6 strobe", 18'(gs), 1);
    chk("R6 unit", 18'(gu), 3);
    chk("R6 function", 18'(gf), 2);
    chk("R6 busy", 18'(busy), 1);
    pio(0, 6'o02, 0); chk("R6 status A cleared", rd, 18'o321000);
    chk("R6 strobe single", 18'(go_strobe), 0);
    pio(0, 6'o22, 0); chk("R6 status B keeps unit 5 attention", rd, 18'o010000);
    pio(0, 6'o44, 18'o000007);
    pio(1, 6'o42, 0); chk("R8 mem addr held", rd, 18'o000055);
    pio(0, 6'o22, 0); chk("R8 programming error", rd, 18'o010400);
    pio(1, 6'o64, 18'o000000);
    pio(0, 6'o02, 0); chk("R8 field held", rd, 18'o321001);
    seq(1, 1, '0, 0, 0);
    chk("R13 busy released", 18'(busy), 0);
    pio(0, 6'o02, 0); chk("R13 done set", rd, 18'o321003);
    pio(0, 6'o44, 18'o000007);
    pio(1, 6'o42, 0); chk("R13 load accepted", rd, 18'o000007);

    // R7 start refused for an active drive
    do_reset();
    drv_active = 8'b0000_0100;
    pio(1, 6'o64, 18'o211000);
    chk("R7 no strobe", 18'(gs), 0);
    chk("R7 not busy", 18'(busy), 0);
    pio(0, 6'o44, 18'o000044);
    pio(1, 6'o42, 0); chk("R7 load accepted", rd, 18'o000044);
    pio(0, 6'o22, 0); chk("R7 no programming error", rd, 0);
    drv_active = '0;

    // R9 clear-status, R13 mask limits
    do_reset();
    pio(0, 6'o04, 18'o777777);
    seq(0, 1, 8'b1000_0001, 18'o777777, 18'o777777);
    pio(0, 6'o02, 0); chk("R13 set A masked", rd, 18'o000763);
    pio(0, 6'o22, 0); chk("R13 set B masked", rd, 18'o402774);
    pio(0, 6'o24, 0);
    pio(0, 6'o02, 0); chk("R9 status A after clear", rd, 18'o000741);
    pio(0, 6'o22, 0); chk("R9 status B after clear", rd, 18'o402000);

    // R10 each error flag alone raises the summary
    for (int b = 2; b <= 8; b++) begin
      do_reset();
      seq(0, 0, '0, 0, 18'(1) << b);
      pio(0, 6'o02, 0); chk("R10 B flag to error", rd, 18'o1);
    end
    for (int b = 4; b <= 8; b++) begin
      do_reset();
      seq(0, 0, '0, 18'(1) << b, 0);
      pio(0, 6'o02, 0); chk("R10 A flag to error", rd, (18'(1) << b) | 18'o1);
    end

    // R11 selected-drive view sweep
    do_reset();
    for (int u = 0; u < 8; u++) begin
      for (int c = 0; c < 32; c++) begin
        logic att, act, skg, wl, bad;
        logic [17:0] ea, eb;
        att = c[0]; act = c[1]; skg = c[2]; wl = c[3]; bad = c[4];
        drv_attached = '1; drv_active = '0; drv_seeking = '0; drv_wlock = '0; drv_cyl = '0;
        drv_attached[u] = att; drv_active[u] = act; drv_seeking[u] = skg; drv_wlock[u] = wl;
        drv_cyl[u*8 +: 8] = bad ? 8'(203 + u) : 8'(u * 7);
        pio(1, 6'o64, 18'(u) << 15);
        ea = (18'(u) << 15) | (wl ? 18'o10 : 18'o0);
        if (att && !act && bad) ea = ea | 18'o4;
        eb = 0;
        if (!att) eb = 18'o001001;
        else if (act && skg) eb = 18'o000003;
        if (ea[2] || eb[9]) ea = ea | 18'o1;
        pio(0, 6'o02, 0); chk("R11 status A", rd, ea);
        pio(0, 6'o22, 0); chk("R11 status B", rd, eb);
        pio(1, 6'o02, 0); chk("R11 cylinder", rd, bad ? 18'(203 + u) : 18'(u * 7));
      end
    end
    drv_attached = '1; drv_active = '0; drv_seeking = '0; drv_wlock = '0; drv_cyl = '0;

    // R12 interrupt and R3 skips
    for (int e = 0; e < 4; e++) begin
      for (int k = 0; k < 8; k++) begin
        logic dn, er, at, eirq;
        dn = k[0]; er = k[1]; at = k[2];
        do_reset();
        seq(0, dn, at ? 8'b0100_0000 : 8'b0, 0, er ? 18'o000100 : 18'o0);
        pio(1, 6'o64, (e[0] ? 18'o004000 : 18'o0) | (e[1] ? 18'o002000 : 18'o0));
        eirq = (e[0] && (dn || er)) || (e[1] && at);
        chk("R12 interrupt", 18'(irq), 18'(eirq));
        pio(0, 6'o01, 0); chk("R3 skip any", 18'(sk), 18'(dn || er || at));
        pio(0, 6'o21, 0); chk("R3 skip attention", 18'(sk), 18'(at));
        pio(0, 6'o41, 0); chk("R3 skip done", 18'(sk), 18'(dn));
        pio(0, 6'o61, 0); chk("R3 skip error", 18'(sk), 18'(er));
        pio(1, 6'o21, 0); chk("R3 skip always", 18'(sk), 1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule